// File: doc/BRIEF.md
# Two-Channel Auto-Reload Interval Timer

This peripheral holds two independent 32-bit interval timers behind a small word-addressed register bus. Software programs a start value into a channel's preset register and sets a control word. The channel then steps its live counter once per clock, up or down. When the counter reaches its end value the channel latches a sticky event flag. It then either reloads the preset and keeps going, which gives a periodic tick (a preset of 1,249,999 on a 125 MHz clock gives 100 Hz), or it disables itself and holds. A level interrupt line reports every latched flag whose channel has its interrupt enabled.

Each channel's behaviour follows from a phase that is decoded every cycle from its stored control word. PH_PRESET applies while the preset-hold bit is set. PH_IDLE applies while the channel is disabled. PH_RUN is ordinary stepping. PH_TERM marks the cycle in which the counter sits at its end value while enabled. The transitions are:
- PRESET to RUN: software clears the hold bit with the enable bit set.
- IDLE to RUN: software sets the enable bit.
- RUN to TERM: the counter steps onto its end value.
- TERM to RUN: auto-reload is on, so the counter reloads.
- TERM to IDLE: auto-reload is off, so the enable bit drops.
- Any phase to PRESET: software sets the hold bit.

Control bits for features this block does not implement are kept and read back, but they have no effect.

Top module: `ivl_timer`

## Requirements
- R1: Channel 0 decodes control at byte offset 0x00, preset at 0x04 and live counter at 0x08. Channel 1 uses 0x10, 0x14 and 0x18. A written preset reads back unchanged. After reset every register reads 0 and `irq` is 0.
- R2: The control word has 11 stored bits. Bit 0 selects the mode, bit 1 sets down counting when 1, bits 2 and 3 enable external features, bit 4 enables auto-reload, bit 5 holds the preset, bit 6 enables the interrupt, bit 7 enables the channel, bit 8 is the event flag, bit 9 enables PWM and bit 10 is a global enable. Bits 11 to 31 read as 0. Bits 0, 2, 3, 9 and 10 read back as written and do not change counting.
- R3: While bit 5 is 1, every clock copies the preset into the counter. This includes a preset written while the hold is active, which the counter takes one clock later. Stepping starts on the clock after the clock that clears bit 5.
- R4: In down mode with the channel enabled, each clock lowers the counter by 1. The end value is 0.
- R5: On the clock at which an enabled counter sits at its end value, bit 8 becomes 1. With auto-reload on, the counter takes the preset at that same clock. A down-counting channel preset to L therefore repeats every L+1 clocks.
- R6: With auto-reload off, the end-value clock clears bit 7 and the counter stays at its end value.
- R7: In up mode (bit 1 = 0) each enabled clock raises the counter by 1. The end value is 0xFFFFFFFF, so the period is 2^32 - L clocks.
- R8: Writing 1 to bit 8 clears the flag, and writing 0 to bit 8 leaves it as it is. Writing back the value just read acknowledges a pending event. If an end value and a clearing write fall on the same clock, the flag is set.
- R9: `irq` is the OR over both channels of flag AND interrupt enable, with no added delay. A flag whose interrupt is disabled does not raise `irq`.
- R10: Offsets 0x0C and 0x1C, and any address with bits 1:0 not zero, read 0. Writes to these addresses and to either counter offset change nothing.
- R11: `rdata` is loaded on the clock at which `rd_en` is high. It returns the register value held just before that clock and keeps it until the next read.
- R12: With bit 7 and bit 5 both 0, the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One-cycle write strobe |
| rd_en | input | 1 | One-cycle read strobe |
| addr | input | 5 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt request |

## Verification
Writes take effect at the clock on which the strobe is sampled. A counter that is released or loaded at clock e holds the value for step t after clock e + t. Its flag becomes visible after clock e + P, where P is the period. `rdata` shows the value held after clock r - 1 for a read strobed at clock r, and `irq` follows the flag within the same cycle. The bench counts clock edges and records the edge of every write and read. It derives each expected counter value, control word and interrupt level from the edge distance to the starting write, and it samples at the falling edge that follows. It sweeps small presets in both directions on both channels, with and without auto-reload, so that each read lands on a different step of the period.

// File: rtl/ivl_timer_pkg.sv
package ivl_timer_pkg;
    localparam int CSR_W  = 11;
    localparam int B_MODE = 0;
    localparam int B_DOWN = 1;
    localparam int B_GEN  = 2;
    localparam int B_CAPT = 3;
    localparam int B_ARLD = 4;
    localparam int B_LOAD = 5;
    localparam int B_IE   = 6;
    localparam int B_EN   = 7;
    localparam int B_STS  = 8;
    localparam int B_PWM  = 9;
    localparam int B_ALL  = 10;

    typedef enum logic [1:0] {
        REG_CSR  = 2'd0,
        REG_LOAD = 2'd1,
        REG_CNT  = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_PRESET,
        PH_RUN,
        PH_TERM
    } phase_e;
endpackage

// File: rtl/ivl_timer_decode.sv
module ivl_timer_decode
    import ivl_timer_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int N_CH   = 2,
    localparam int CH_W  = ADDR_W - 4
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [CH_W-1:0]   ch_idx,
    output reg_sel_e          sel,
    output logic              hit
);
    always_comb begin
        ch_idx = addr[ADDR_W-1:4];
        sel    = reg_sel_e'(addr[3:2]);
        hit    = (addr[1:0] == 2'b00) && (sel != REG_NONE)
                 && (32'(ch_idx) < N_CH);
    end
endmodule

// File: rtl/ivl_timer_chan.sv
module ivl_timer_chan
    import ivl_timer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             csr_we,
    input  logic             load_we,
    input  logic [CNT_W-1:0] wdata,
    output logic [CSR_W-1:0] csr_q,
    output logic [CNT_W-1:0] load_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic             irq_o
);
    phase_e           phase;
    logic             at_term;
    logic [CSR_W-1:0] csr_d;
    logic [CNT_W-1:0] cnt_d;

    // phase decode from the stored control word
    always_comb begin
        at_term = csr_q[B_DOWN] ? (cnt_q == '0) : (cnt_q == '1);
        if (csr_q[B_LOAD])     phase = PH_PRESET;
        else if (!csr_q[B_EN]) phase = PH_IDLE;
        else if (at_term)      phase = PH_TERM;
        else                   phase = PH_RUN;
    end

    // next-state for counter and control word, per phase
    always_comb begin
        cnt_d = cnt_q;
        csr_d = csr_q;
        if (csr_we) begin
            csr_d        = wdata[CSR_W-1:0];
            csr_d[B_STS] = csr_q[B_STS] & ~wdata[B_STS];
        end
        unique case (phase)
            PH_PRESET: cnt_d = load_q;
            PH_IDLE:   cnt_d = cnt_q;
            PH_RUN:    cnt_d = csr_q[B_DOWN] ? cnt_q - 1'b1 : cnt_q + 1'b1;
            PH_TERM: begin
                csr_d[B_STS] = 1'b1;
                if (csr_q[B_ARLD])  cnt_d = load_q;
                else if (!csr_we)   csr_d[B_EN] = 1'b0;
            end
        endcase
    end

    // state registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            csr_q  <= '0;
            load_q <= '0;
            cnt_q  <= '0;
        end else begin
            csr_q <= csr_d;
            cnt_q <= cnt_d;
            if (load_we) load_q <= wdata;
        end
    end

    assign irq_o = csr_q[B_STS] & csr_q[B_IE];

    assert_preset_copies_R3: assert property (@(posedge clk) disable iff (!rst_n)
        csr_q[B_LOAD] |=> (cnt_q == $past(load_q)));
    assert_down_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_RUN && csr_q[B_DOWN]) |=> (cnt_q == $past(cnt_q) - 1'b1));
    assert_term_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_TERM) |=> csr_q[B_STS]);
    assert_oneshot_stops_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_TERM && !csr_q[B_ARLD] && !csr_we) |=> (!csr_q[B_EN] && $stable(cnt_q)));
    assert_w1c_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we && wdata[B_STS] && phase != PH_TERM) |=> !csr_q[B_STS]);
    assert_idle_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!csr_q[B_LOAD] && !csr_q[B_EN]) |=> $stable(cnt_q));
endmodule

// File: rtl/ivl_timer.sv
module ivl_timer
    import ivl_timer_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int N_CH   = 2,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  rdata,
    output logic              irq
);
    localparam int CH_W = ADDR_W - 4;

    logic [CH_W-1:0]  ch_idx;
    reg_sel_e         sel;
    logic             hit;
    logic [CSR_W-1:0] csr_arr  [N_CH];
    logic [CNT_W-1:0] load_arr [N_CH];
    logic [CNT_W-1:0] cnt_arr  [N_CH];
    logic [N_CH-1:0]  ch_irq;
    logic [CNT_W-1:0] rd_mux;

    ivl_timer_decode #(.ADDR_W(ADDR_W), .N_CH(N_CH)) dec_i (
        .addr   (addr),
        .ch_idx (ch_idx),
        .sel    (sel),
        .hit    (hit)
    );

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        logic sel_me;
        assign sel_me = wr_en && hit && (ch_idx == CH_W'(i));
        ivl_timer_chan #(.CNT_W(CNT_W)) chan_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .csr_we  (sel_me && sel == REG_CSR),
            .load_we (sel_me && sel == REG_LOAD),
            .wdata   (wdata),
            .csr_q   (csr_arr[i]),
            .load_q  (load_arr[i]),
            .cnt_q   (cnt_arr[i]),
            .irq_o   (ch_irq[i])
        );
    end

    assign irq = |ch_irq;

    always_comb begin
        rd_mux = '0;
        if (hit) begin
            case (sel)
                REG_CSR:  rd_mux = CNT_W'(csr_arr[ch_idx]);
                REG_LOAD: rd_mux = load_arr[ch_idx];
                REG_CNT:  rd_mux = cnt_arr[ch_idx];
                default:  rd_mux = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_mux;
    end

    assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !hit) |=> (rdata == '0));
    assert_rdata_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));
endmodule

// File: tb/ivl_timer_tb.sv
`timescale 1ns/1ps
module ivl_timer_tb_top;
    localparam logic [31:0] M_DOWN = 32'h002, M_ARLD = 32'h010, M_LOAD = 32'h020;
    localparam logic [31:0] M_IE = 32'h040, M_EN = 32'h080, M_STS = 32'h100;
    localparam logic [31:0] M_INERT = 32'h60D; // bits 0,2,3,9,10

    logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    int          cyc = 0, last_edge = 0, nchk = 0, nerr = 0;
    logic [31:0] rv;

    ivl_timer dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
                     .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0; last_edge = cyc;
    endtask

    task automatic rd(input logic [4:0] a);
        @(negedge clk); rd_en = 1'b1; addr = a;
        @(negedge clk); rd_en = 1'b0; rv = rdata; last_edge = cyc;
    endtask

    function automatic logic [31:0] exp_cnt(input longint L, input longint t,
                                            input bit down, input bit arld);
        longint p = down ? L + 1 : 64'h1_0000_0000 - L;
        if (arld) return down ? 32'(L - (t % p)) : 32'(L + (t % p));
        if (t >= p - 1) return down ? 32'h0 : 32'hFFFF_FFFF;
        return down ? 32'(L - t) : 32'(L + t);
    endfunction

    task automatic stop_ch(input logic [4:0] base);
        wr(base, 32'h0);
        wr(base, M_STS);
    endtask

    task automatic run_case(input int ch, input logic [31:0] L, input bit down,
                            input bit arld, input bit ie, input logic [31:0] extra,
                            input string tag);
        logic [4:0]  base = 5'(ch * 16);
        logic [31:0] ctrl, expc;
        longint      p, t;
        int          e;
        ctrl = M_EN | (down ? M_DOWN : 0) | (arld ? M_ARLD : 0) | (ie ? M_IE : 0) | extra;
        p = down ? longint'(L) + 1 : 64'h1_0000_0000 - longint'(L);
        wr(base + 5'h4, L);
        wr(base, M_LOAD | M_STS);
        wr(base, ctrl | M_STS);
        e = last_edge;
        for (int k = 0; k < int'(2 * p + 3); k++) begin
            rd(base + 5'h8);
            t = longint'(last_edge - 1 - e);
            check(tag, "count", rv, exp_cnt(longint'(L), t, down, arld));
            rd(base);
            t = longint'(last_edge - 1 - e);
            expc = ctrl;
            if (t >= p) begin
                expc = expc | M_STS;
                if (!arld) expc = expc & ~M_EN;
            end
            check(tag, "csr", rv, expc);
            t = longint'(last_edge - e);
            check("R9", "irq", 32'(irq), 32'(ie && t >= p));
        end
        stop_ch(base);
    endtask

    initial begin
        #(200000 * 4);
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        int e;
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1", "irq after reset", 32'(irq), 0);
        for (int c = 0; c < 2; c++)
            for (int r = 0; r < 3; r++) begin
                rd(5'(c * 16 + r * 4));
                check("R1", "reset read", rv, 0);
            end
        // R1 preset read-back
        wr(5'h04, 32'hA5A5_1234); rd(5'h04); check("R1", "preset0", rv, 32'hA5A5_1234);
        wr(5'h14, 32'h0F0F_F0F0); rd(5'h14); check("R1", "preset1", rv, 32'h0F0F_F0F0);
        // R2 upper bits zero, flag not set by writing 1
        wr(5'h00, 32'hFFFF_FFFF); rd(5'h00); check("R2", "csr mask", rv, 32'h0000_06FF);
        wr(5'h00, 32'h0);         rd(5'h08); check("R3", "held preset", rv, 32'hA5A5_1234);
        // R12 idle hold
        repeat (5) @(negedge clk);
        rd(5'h08); check("R12", "idle count", rv, 32'hA5A5_1234);
        // R10 unmapped and read-only
        wr(5'h08, 32'h1111_1111); wr(5'h0C, 32'h2222_2222); wr(5'h05, 32'h3333_3333);
        rd(5'h08); check("R10", "counter write ignored", rv, 32'hA5A5_1234);
        rd(5'h04); check("R10", "preset untouched", rv, 32'hA5A5_1234);
        rd(5'h0C); check("R10", "0x0C", rv, 0);
        rd(5'h1C); check("R10", "0x1C", rv, 0);
        rd(5'h01); check("R10", "unaligned", rv, 0);
        // R11 rdata holds without a strobe
        repeat (4) @(negedge clk);
        check("R11", "rdata hold", rdata, 0);
        // R4 R5 down auto-reload sweep on both channels
        for (int c = 0; c < 2; c++)
            for (int L = 0; L < 7; L++)
                run_case(c, 32'(L), 1'b1, 1'b1, 1'b1, 32'h0, "R4 R5");
        // R6 one-shot down
        for (int L = 0; L < 6; L += 2) run_case(1, 32'(L), 1'b1, 1'b0, 1'b1, 32'h0, "R6");
        // R7 up mode, reload and one-shot
        run_case(0, 32'hFFFF_FFFF, 1'b0, 1'b1, 1'b1, 32'h0, "R7");
        run_case(1, 32'hFFFF_FFFA, 1'b0, 1'b1, 1'b1, 32'h0, "R7");
        run_case(0, 32'hFFFF_FFF4, 1'b0, 1'b0, 1'b1, 32'h0, "R7 R6");
        // R2 inert bits, R9 interrupt disabled
        run_case(0, 32'd4, 1'b1, 1'b1, 1'b0, M_INERT, "R2");
        run_case(1, 32'd3, 1'b0 , 1'b1, 1'b0, 32'h0, "R9");
        // R3 held preset follows new preset, release starts stepping
        wr(5'h04, 32'd100);
        wr(5'h00, M_LOAD | M_EN | M_DOWN);
        repeat (3) @(negedge clk);
        rd(5'h08); check("R3", "hold value", rv, 32'd100);
        wr(5'h04, 32'd7);
        repeat (2) @(negedge clk);
        rd(5'h08); check("R3", "new preset taken", rv, 32'd7);
        wr(5'h00, M_EN | M_DOWN); e = last_edge;
        repeat (2) @(negedge clk);
        rd(5'h08); check("R3", "release", rv, exp_cnt(7, longint'(last_edge - 1 - e), 1'b1, 1'b0));
        stop_ch(5'h00);
        // R10 counter write while running
        wr(5'h04, 32'd50); wr(5'h00, M_LOAD); wr(5'h00, M_EN | M_DOWN | M_ARLD); e = last_edge;
        wr(5'h08, 32'h1234);
        rd(5'h08); check("R10", "running counter write", rv,
                         exp_cnt(50, longint'(last_edge - 1 - e), 1'b1, 1'b1));
        stop_ch(5'h00);
        // R8 acknowledge by write-back
        wr(5'h14, 32'd2); wr(5'h10, M_LOAD); wr(5'h10, M_EN | M_DOWN | M_IE);
        repeat (8) @(negedge clk);
        check("R8", "irq pending", 32'(irq), 1);
        rd(5'h10); v = rv;
        check("R8", "flag set", v, M_DOWN | M_IE | M_STS);
        wr(5'h10, v & ~M_STS);
        rd(5'h10); check("R8", "write 0 keeps flag", rv, v);
        wr(5'h10, v);
        rd(5'h10); check("R8", "write-back clears", rv, v & ~M_STS);
        check("R8", "irq cleared", 32'(irq), 0);
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule